// File: doc/BRIEF.md
# Vector Floating-Point Scalar Move Unit

This unit executes the two scalar moves between the vector register file and the floating-point register file. The first copies element 0 of a vector register into a 64-bit floating-point register. The second copies a floating-point register into element 0 of a vector register. The unit accepts a 32-bit instruction word together with the current vector configuration: the invalid-configuration flag, the element width and the active length. It also takes the FP unit status field and two flags that say whether single and double precision are present.

Operands are read through combinational read ports whose addresses come straight from the instruction word. One cycle after an accepted instruction, a one-cycle `done` pulse carries these results:
- whether the word was recognised;
- whether it raised an illegal-instruction condition;
- the register-file write, if any;
- a request to mark the FP status as dirty.

Values narrower than 64 bits placed in an FP register are NaN-boxed, meaning all bits above the value are set to 1. A vector destination keeps only element 0, and every byte above it is cleared.

Top module: `vfsmove_unit`

## Requirements
- R1: The vector-to-FP move is the word with bits [31:26]=001100, [25]=1, [19:15]=00000, [14:12]=001 and [6:0]=1010111; the source vector is [24:20] and the FP destination is [11:7]. The FP-to-vector move is [31:26]=001101, [25]=1, [24:20]=00000, [14:12]=101 with the same opcode; the FP source is [19:15] and the vector destination is [11:7]. Any other word gives `handled`=0 with no write, no illegal report and no dirty request.
- R2: Either move raises `illegal`, and performs no write, when the invalid-configuration flag is set, when single precision is absent, or when SEW is 8 bits. SEW is encoded as 0=8, 1=16, 2=32 and 3=64 bits.
- R3: The vector-to-FP move is also illegal when the FP status field is 0. The FP-to-vector move does not depend on that field.
- R4: For the vector-to-FP move with SEW 16 or 32, the FP destination receives the low SEW bits of the vector register, and all bits above them are set to 1.
- R5: For the vector-to-FP move with SEW 64, the FP destination receives bits [63:0] unchanged when double precision is present. Otherwise it receives bits [31:0] with the upper 32 bits set to 1.
- R6: `fs_dirty` is asserted exactly when a legal vector-to-FP move writes the FP register file, and at no other time.
- R7: An FP-to-vector move with vl=0 is recognised and legal, but it writes nothing and reports nothing illegal.
- R8: An FP-to-vector move with vl>0 writes the low SEW bits of the FP source into bits [SEW-1:0] of the destination vector register. All bits from SEW up to VLEN-1 are written as zero.
- R9: For an FP-to-vector move with SEW 64 and no double precision, bits [63:32] of the written element are all ones.
- R10: Results appear in the cycle after `in_valid`, qualified by a one-cycle `done`. The write enables, `illegal` and `fs_dirty` are never asserted without `done`, and all of them are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and state are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_vill | input | 1 | Vector configuration is invalid |
| in_sew | input | 2 | Element width code (0=8, 1=16, 2=32, 3=64) |
| in_vl | input | $clog2(VLEN)+1 | Active vector length |
| in_fs | input | 2 | FP unit status field (0 = off) |
| in_has_f | input | 1 | Single precision present |
| in_has_d | input | 1 | Double precision present |
| vrf_rd_addr | output | 5 | Vector read address |
| vrf_rd_data | input | VLEN | Vector read data |
| vrf_wr_en | output | 1 | Vector write enable |
| vrf_wr_addr | output | 5 | Vector write address |
| vrf_wr_data | output | VLEN | Vector write data |
| fprf_rd_addr | output | 5 | FP read address |
| fprf_rd_data | input | 64 | FP read data |
| fprf_wr_en | output | 1 | FP write enable |
| fprf_wr_addr | output | 5 | FP write address |
| fprf_wr_data | output | 64 | FP write data |
| done | output | 1 | Result pulse for the instruction of the previous cycle |
| handled | output | 1 | The word was one of the two moves |
| illegal | output | 1 | Illegal-instruction condition |
| fs_dirty | output | 1 | Request to mark the FP status dirty |

## Verification
A legal vector-to-FP move drives two results in the same `done` cycle: the FP register write and the dirty-status request. The bench provokes this with legal moves at every element width and with double precision both present and absent. Each time it compares the boxed data and the dirty flag together against a single expected entry.

Illegal variants must show that both results are absent together. These include a zero FP status field, the invalid-configuration flag and 8-bit SEW. Back-to-back issue checks that neither result leaks into a neighbouring cycle.

// File: rtl/vfsm_pkg.sv
package vfsm_pkg;
  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_V_TO_F = 2'd1,
    OP_F_TO_V = 2'd2
  } mv_op_e;

  localparam logic [6:0] OPC_VEC    = 7'b1010111;
  localparam logic [5:0] F6_V_TO_F  = 6'b001100;
  localparam logic [5:0] F6_F_TO_V  = 6'b001101;
  localparam logic [2:0] F3_V_TO_F  = 3'b001;
  localparam logic [2:0] F3_F_TO_V  = 3'b101;

  // Number of bytes that carry payload for a given width; 64-bit without
  // double precision narrows to a single-precision payload.
  function automatic logic [3:0] payload_bytes(input sew_e sew, input logic has_d);
    case (sew)
      SEW_8:   payload_bytes = 4'd1;
      SEW_16:  payload_bytes = 4'd2;
      SEW_32:  payload_bytes = 4'd4;
      default: payload_bytes = has_d ? 4'd8 : 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/vfsm_rst_sync.sv
module vfsm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/vfsm_decode.sv
module vfsm_decode
  import vfsm_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        vill,
  input  sew_e        sew,
  input  logic [1:0]  fs,
  input  logic        has_f,
  output mv_op_e      op,
  output logic [4:0]  vsrc_idx,
  output logic [4:0]  fsrc_idx,
  output logic [4:0]  dst_idx,
  output logic        legal
);
  logic [5:0] f6;
  logic       vm_bit;
  logic [4:0] fld_hi;
  logic [4:0] fld_lo;
  logic [2:0] f3;
  logic [6:0] opc;
  logic       is_v2f;
  logic       is_f2v;
  logic       base_ok;

  always_comb begin
    f6     = insn[31:26];
    vm_bit = insn[25];
    fld_hi = insn[24:20];
    fld_lo = insn[19:15];
    f3     = insn[14:12];
    opc    = insn[6:0];

    is_v2f = (opc == OPC_VEC) && (f6 == F6_V_TO_F) && vm_bit &&
             (fld_lo == 5'd0) && (f3 == F3_V_TO_F);
    is_f2v = (opc == OPC_VEC) && (f6 == F6_F_TO_V) && vm_bit &&
             (fld_hi == 5'd0) && (f3 == F3_F_TO_V);

    if (is_v2f)      op = OP_V_TO_F;
    else if (is_f2v) op = OP_F_TO_V;
    else             op = OP_NONE;

    base_ok = !vill && has_f && (sew != SEW_8);
    case (op)
      OP_V_TO_F: legal = base_ok && (fs != 2'd0);
      OP_F_TO_V: legal = base_ok;
      default:   legal = 1'b0;
    endcase

    vsrc_idx = fld_hi;
    fsrc_idx = fld_lo;
    dst_idx  = insn[11:7];
  end
endmodule

// File: rtl/vfsm_box.sv
// Element 0 to 64-bit FP value: payload bytes pass, the rest become all ones.
module vfsm_box
  import vfsm_pkg::*;
(
  input  logic [63:0] elem,
  input  sew_e        sew,
  input  logic        has_d,
  output logic [63:0] fp_val
);
  logic [3:0] n_bytes;

  assign n_bytes = payload_bytes(sew, has_d);

  for (genvar b = 0; b < 8; b++) begin : g_lane
    always_comb begin
      if (4'(b) < n_bytes) fp_val[8*b +: 8] = elem[8*b +: 8];
      else                 fp_val[8*b +: 8] = 8'hFF;
    end
  end
endmodule

// File: rtl/vfsm_insert.sv
// FP value to a full vector register image: element 0 in the low bytes,
// everything above it zero.
module vfsm_insert
  import vfsm_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [63:0]     fp_val,
  input  sew_e            sew,
  input  logic            has_d,
  output logic [VLEN-1:0] vec
);
  localparam int NBYTES = VLEN / 8;

  logic [3:0]  n_bytes;
  logic [63:0] src;

  always_comb begin
    n_bytes = payload_bytes(sew, 1'b1);
    src     = fp_val;
    if (sew == SEW_64 && !has_d) src[63:32] = 32'hFFFF_FFFF;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (b < 8) begin : g_elem
      always_comb begin
        if (4'(b) < n_bytes) vec[8*b +: 8] = src[8*b +: 8];
        else                 vec[8*b +: 8] = 8'h00;
      end
    end else begin : g_tail
      assign vec[8*b +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/vfsmove_unit.sv
module vfsmove_unit
  import vfsm_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic            in_vill,
  input  logic [1:0]      in_sew,
  input  logic [VLW-1:0]  in_vl,
  input  logic [1:0]      in_fs,
  input  logic            in_has_f,
  input  logic            in_has_d,
  output logic [4:0]      vrf_rd_addr,
  input  logic [VLEN-1:0] vrf_rd_data,
  output logic            vrf_wr_en,
  output logic [4:0]      vrf_wr_addr,
  output logic [VLEN-1:0] vrf_wr_data,
  output logic [4:0]      fprf_rd_addr,
  input  logic [63:0]     fprf_rd_data,
  output logic            fprf_wr_en,
  output logic [4:0]      fprf_wr_addr,
  output logic [63:0]     fprf_wr_data,
  output logic            done,
  output logic            handled,
  output logic            illegal,
  output logic            fs_dirty
);
  logic            rst_n_s;
  mv_op_e          op;
  logic [4:0]      vsrc_idx;
  logic [4:0]      fsrc_idx;
  logic [4:0]      dst_idx;
  logic            legal;
  sew_e            sew;
  logic [63:0]     boxed;
  logic [VLEN-1:0] vimage;

  logic            done_d, handled_d, illegal_d, vwe_d, fwe_d;
  logic            done_q, handled_q, illegal_q, vwe_q, fwe_q;
  logic [4:0]      addr_q;
  logic [VLEN-1:0] vdata_q;
  logic [63:0]     fdata_q;

  assign sew = sew_e'(in_sew);

  vfsm_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  vfsm_decode i_decode (
    .insn     (in_insn),
    .vill     (in_vill),
    .sew      (sew),
    .fs       (in_fs),
    .has_f    (in_has_f),
    .op       (op),
    .vsrc_idx (vsrc_idx),
    .fsrc_idx (fsrc_idx),
    .dst_idx  (dst_idx),
    .legal    (legal)
  );

  assign vrf_rd_addr  = vsrc_idx;
  assign fprf_rd_addr = fsrc_idx;

  vfsm_box i_box (
    .elem   (vrf_rd_data[63:0]),
    .sew    (sew),
    .has_d  (in_has_d),
    .fp_val (boxed)
  );

  vfsm_insert #(.VLEN(VLEN)) i_insert (
    .fp_val (fprf_rd_data),
    .sew    (sew),
    .has_d  (in_has_d),
    .vec    (vimage)
  );

  // Next-state
  always_comb begin
    done_d    = in_valid;
    handled_d = in_valid && (op != OP_NONE);
    illegal_d = handled_d && !legal;
    fwe_d     = handled_d && legal && (op == OP_V_TO_F);
    vwe_d     = handled_d && legal && (op == OP_F_TO_V) && (in_vl != '0);
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q    <= 1'b0;
      handled_q <= 1'b0;
      illegal_q <= 1'b0;
      vwe_q     <= 1'b0;
      fwe_q     <= 1'b0;
    end else begin
      done_q    <= done_d;
      handled_q <= handled_d;
      illegal_q <= illegal_d;
      vwe_q     <= vwe_d;
      fwe_q     <= fwe_d;
    end
  end

  // Data registers, enabled only by an accepted instruction
  always_ff @(posedge clk) begin
    if (in_valid) begin
      addr_q  <= dst_idx;
      vdata_q <= vimage;
      fdata_q <= boxed;
    end
  end

  assign done         = done_q;
  assign handled      = handled_q;
  assign illegal      = illegal_q;
  assign vrf_wr_en    = vwe_q;
  assign fprf_wr_en   = fwe_q;
  assign fs_dirty     = fwe_q;
  assign vrf_wr_addr  = addr_q;
  assign fprf_wr_addr = addr_q;
  assign vrf_wr_data  = vdata_q;
  assign fprf_wr_data = fdata_q;
endmodule

// File: rtl/vfsm_checker.sv
module vfsm_checker #(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_sew,
  input logic [VLW-1:0]  in_vl,
  input logic            vrf_wr_en,
  input logic [VLEN-1:0] vrf_wr_data,
  input logic            fprf_wr_en,
  input logic [63:0]     fprf_wr_data,
  input logic            done,
  input logic            handled,
  input logic            illegal,
  input logic            fs_dirty
);
  a_r10_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  a_r10_outputs_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (vrf_wr_en || fprf_wr_en || illegal || fs_dirty) |-> (done && handled));

  a_r2_exclusive_results: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vrf_wr_en, fprf_wr_en, illegal}));

  a_r6_dirty_with_fp_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fs_dirty == fprf_wr_en));

  a_r7_zero_vl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vl == '0) |=> !vrf_wr_en);

  a_r4_box_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sew == 2'd1) |=> (!fprf_wr_en || (&fprf_wr_data[63:16])));

  a_r8_tail_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sew == 2'd2) |=> (!vrf_wr_en || (vrf_wr_data[VLEN-1:32] == '0)));

  a_r1_unhandled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !handled) |-> !(vrf_wr_en || fprf_wr_en || illegal));
endmodule

bind vfsmove_unit vfsm_checker #(.VLEN(VLEN)) i_vfsm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_sew       (in_sew),
  .in_vl        (in_vl),
  .vrf_wr_en    (vrf_wr_en),
  .vrf_wr_data  (vrf_wr_data),
  .fprf_wr_en   (fprf_wr_en),
  .fprf_wr_data (fprf_wr_data),
  .done         (done),
  .handled      (handled),
  .illegal      (illegal),
  .fs_dirty     (fs_dirty)
);

// File: tb/test_vfsmove_unit.sv
module test_vfsmove_unit;
  localparam int VLEN = 128;
  localparam int VLW  = $clog2(VLEN) + 1;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_insn;
  logic            in_vill;
  logic [1:0]      in_sew;
  logic [VLW-1:0]  in_vl;
  logic [1:0]      in_fs;
  logic            in_has_f;
  logic            in_has_d;
  logic [4:0]      vrf_rd_addr;
  logic [VLEN-1:0] vrf_rd_data;
  logic            vrf_wr_en;
  logic [4:0]      vrf_wr_addr;
  logic [VLEN-1:0] vrf_wr_data;
  logic [4:0]      fprf_rd_addr;
  logic [63:0]     fprf_rd_data;
  logic            fprf_wr_en;
  logic [4:0]      fprf_wr_addr;
  logic [63:0]     fprf_wr_data;
  logic            done;
  logic            handled;
  logic            illegal;
  logic            fs_dirty;

  logic [VLEN-1:0] vregs [32];
  logic [63:0]     fregs [32];

  assign vrf_rd_data  = vregs[vrf_rd_addr];
  assign fprf_rd_data = fregs[fprf_rd_addr];

  vfsmove_unit #(.VLEN(VLEN)) i_vfsmove_unit (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    bit              handled;
    bit              illegal;
    bit              vwe;
    bit              fwe;
    logic [4:0]      addr;
    logic [VLEN-1:0] vdata;
    logic [63:0]     fdata;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 0;
  bit   mon_on   = 0;

  function automatic logic [31:0] enc_v2f(input logic [4:0] vs, input logic [4:0] fd);
    return {6'b001100, 1'b1, vs, 5'b00000, 3'b001, fd, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_f2v(input logic [4:0] fsrc, input logic [4:0] vd);
    return {6'b001101, 1'b1, 5'b00000, fsrc, 3'b101, vd, 7'b1010111};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic vill, input logic [1:0] sew,
                                 input logic [VLW-1:0] vl, input logic [1:0] fs,
                                 input logic hf, input logic hd, input string tag);
    exp_t e;
    logic [63:0] s;
    logic ok;
    e.handled = 0; e.illegal = 0; e.vwe = 0; e.fwe = 0;
    e.addr = w[11:7]; e.vdata = '0; e.fdata = '0; e.tag = tag;
    ok = !vill && hf && (sew != 2'd0);
    if (w == enc_v2f(w[24:20], w[11:7])) begin
      e.handled = 1;
      if (!ok || fs == 2'd0) e.illegal = 1;
      else begin
        e.fwe = 1;
        s = vregs[w[24:20]][63:0];
        case (sew)
          2'd1:    e.fdata = {48'hFFFF_FFFF_FFFF, s[15:0]};
          2'd2:    e.fdata = {32'hFFFF_FFFF, s[31:0]};
          default: e.fdata = hd ? s : {32'hFFFF_FFFF, s[31:0]};
        endcase
      end
    end else if (w == enc_f2v(w[19:15], w[11:7])) begin
      e.handled = 1;
      if (!ok) e.illegal = 1;
      else if (vl != '0) begin
        e.vwe = 1;
        s = fregs[w[19:15]];
        case (sew)
          2'd1:    e.vdata[15:0] = s[15:0];
          2'd2:    e.vdata[31:0] = s[31:0];
          default: e.vdata[63:0] = hd ? s : {32'hFFFF_FFFF, s[31:0]};
        endcase
      end
    end
    return e;
  endfunction

  task automatic issue(input logic [31:0] w, input logic vill, input logic [1:0] sew,
                       input logic [VLW-1:0] vl, input logic [1:0] fs,
                       input logic hf, input logic hd, input string tag);
    @(negedge clk);
    in_valid = 1; in_insn = w; in_vill = vill; in_sew = sew; in_vl = vl;
    in_fs = fs; in_has_f = hf; in_has_d = hd;
    q.push_back(model(w, vill, sew, vl, fs, hf, hd, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        exp_t e;
        n_checks++;
        if (q.size() == 0) begin
          n_fails++;
          $display("FAIL R10: done=1 act with no expected item exp done=0");
        end else begin
          e = q.pop_front();
          if (handled !== e.handled || illegal !== e.illegal || vrf_wr_en !== e.vwe ||
              fprf_wr_en !== e.fwe || fs_dirty !== e.fwe ||
              (e.vwe && (vrf_wr_addr !== e.addr || vrf_wr_data !== e.vdata)) ||
              (e.fwe && (fprf_wr_addr !== e.addr || fprf_wr_data !== e.fdata))) begin
            n_fails++;
            $display("FAIL %s: act h=%0b il=%0b vwe=%0b fwe=%0b dirty=%0b a=%0d v=%h f=%h exp h=%0b il=%0b vwe=%0b fwe=%0b a=%0d v=%h f=%h",
                     e.tag, handled, illegal, vrf_wr_en, fprf_wr_en, fs_dirty,
                     (vrf_wr_en ? vrf_wr_addr : fprf_wr_addr), vrf_wr_data, fprf_wr_data,
                     e.handled, e.illegal, e.vwe, e.fwe, e.addr, e.vdata, e.fdata);
          end
        end
      end else if (vrf_wr_en || fprf_wr_en || illegal || fs_dirty) begin
        n_checks++;
        n_fails++;
        $display("FAIL R10: act outputs active without done exp all 0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: act run hung exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < VLEN / 32; k++)
        vregs[i][32*k +: 32] = 32'h9E37_79B9 * (i + 1) + 32'h0101_0101 * k + 32'h1357;
      fregs[i] = {32'h4000_0000 + 32'(i * 977), 32'h3F80_1234 ^ 32'(i * 31)};
    end
    rst_n = 0; in_valid = 0; in_insn = '0; in_vill = 0; in_sew = 2'd2;
    in_vl = 1; in_fs = 2'd1; in_has_f = 1; in_has_d = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    n_checks++;
    if (done !== 0 || vrf_wr_en !== 0 || fprf_wr_en !== 0 || illegal !== 0 || fs_dirty !== 0) begin
      n_fails++;
      $display("FAIL R10: reset act done=%0b vwe=%0b fwe=%0b il=%0b dirty=%0b exp all 0",
               done, vrf_wr_en, fprf_wr_en, illegal, fs_dirty);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1: decoding and near misses
    issue(32'h0000_0013, 0, 2'd2, 8'd4, 2'd1, 1, 1, "R1 unrelated word");
    issue(enc_v2f(5'd3, 5'd4) & ~32'h0200_0000, 0, 2'd2, 8'd4, 2'd1, 1, 1, "R1 vm clear");
    issue(enc_v2f(5'd3, 5'd4) | 32'h0000_8000, 0, 2'd2, 8'd4, 2'd1, 1, 1, "R1 rs1 nonzero");
    issue(enc_f2v(5'd2, 5'd5) | 32'h0010_0000, 0, 2'd2, 8'd4, 2'd1, 1, 1, "R1 vs2 nonzero");
    issue(enc_f2v(5'd2, 5'd5) ^ 32'h0000_4000, 0, 2'd2, 8'd4, 2'd1, 1, 1, "R1 funct3 wrong");
    idle();
    // R2: illegal conditions
    issue(enc_v2f(5'd1, 5'd2), 1, 2'd2, 8'd4, 2'd1, 1, 1, "R2 vill v2f");
    issue(enc_f2v(5'd1, 5'd2), 1, 2'd2, 8'd4, 2'd1, 1, 1, "R2 vill f2v");
    issue(enc_v2f(5'd1, 5'd2), 0, 2'd2, 8'd4, 2'd1, 0, 1, "R2 no F v2f");
    issue(enc_f2v(5'd1, 5'd2), 0, 2'd2, 8'd4, 2'd1, 0, 1, "R2 no F f2v");
    issue(enc_v2f(5'd1, 5'd2), 0, 2'd0, 8'd4, 2'd1, 1, 1, "R2 sew8 v2f");
    issue(enc_f2v(5'd1, 5'd2), 0, 2'd0, 8'd4, 2'd1, 1, 1, "R2 sew8 f2v");
    // R3 / R6: FP status field
    issue(enc_v2f(5'd6, 5'd7), 0, 2'd2, 8'd4, 2'd0, 1, 1, "R3 fs off v2f");
    issue(enc_f2v(5'd6, 5'd7), 0, 2'd2, 8'd4, 2'd0, 1, 1, "R3 fs off f2v legal");
    issue(enc_v2f(5'd6, 5'd7), 0, 2'd2, 8'd4, 2'd3, 1, 1, "R6 write with dirty");
    idle();
    // R4 / R5 boxing
    issue(enc_v2f(5'd9, 5'd10), 0, 2'd1, 8'd4, 2'd1, 1, 1, "R4 sew16 box");
    issue(enc_v2f(5'd11, 5'd12), 0, 2'd2, 8'd4, 2'd2, 1, 0, "R4 sew32 box");
    issue(enc_v2f(5'd13, 5'd14), 0, 2'd3, 8'd2, 2'd1, 1, 1, "R5 sew64 with D");
    issue(enc_v2f(5'd15, 5'd16), 0, 2'd3, 8'd2, 2'd1, 1, 0, "R5 sew64 no D");
    idle();
    // R7 / R8 / R9 vector writes
    issue(enc_f2v(5'd17, 5'd18), 0, 2'd2, 8'd0, 2'd1, 1, 1, "R7 vl zero");
    issue(enc_f2v(5'd19, 5'd20), 0, 2'd1, 8'd1, 2'd1, 1, 1, "R8 sew16 tail");
    issue(enc_f2v(5'd21, 5'd22), 0, 2'd2, 8'd16, 2'd0, 1, 0, "R8 sew32 tail");
    issue(enc_f2v(5'd23, 5'd24), 0, 2'd3, 8'd2, 2'd1, 1, 1, "R8 sew64 with D");
    issue(enc_f2v(5'd25, 5'd26), 0, 2'd3, 8'd2, 2'd1, 1, 0, "R9 sew64 no D");
    // R10 back-to-back mixing
    issue(enc_v2f(5'd31, 5'd0), 0, 2'd1, 8'd8, 2'd1, 1, 1, "R10 b2b v2f");
    issue(enc_f2v(5'd31, 5'd30), 0, 2'd1, 8'd8, 2'd1, 1, 1, "R10 b2b f2v");
    issue(32'hFFFF_FFFF, 0, 2'd1, 8'd8, 2'd1, 1, 1, "R10 b2b none");
    issue(enc_v2f(5'd4, 5'd29), 0, 2'd3, 8'd8, 2'd1, 1, 0, "R10 b2b v2f noD");
    idle();
    repeat (4) @(negedge clk);
    n_checks++;
    if (q.size() != 0) begin
      n_fails++;
      $display("FAIL R10: act %0d results missing exp 0", q.size());
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule